// File: doc/BRIEF.md
# Single-to-half precision pair splitter

This unit takes one single-precision (32-bit) floating-point value and produces two half-precision (16-bit) values whose scaled sum reproduces it. The first output, the high half, is the input rounded to half precision. The second output, the low half, is the exact difference between the input and the high half. That difference is multiplied by 2^11 before it is rounded to half precision, so small residuals do not underflow. A consumer that has only a half-precision multiplier can then form a product with close to full single-precision accuracy. It multiplies the two halves separately and recombines the results as high + low / 2^lo_scale.

The unit has one register stage. A value presented with `in_valid` high appears on the outputs one clock later, with `out_valid` high. The scale exponent is fixed at 11 and is driven on `lo_scale` so that the consumer can undo it. Not-a-number, infinite and out-of-range inputs follow simple saturation rules, and in each of those cases the low half is zero.

Top module: `fp32_half_splitter`

## Requirements
- R1: `out_valid` equals `in_valid` delayed by one clock. While `rst_n` is low and on the first edge after it, `out_valid`, `hi_half` and `lo_half` are all zero.
- R2: On a clock edge where `in_valid` is low, `hi_half` and `lo_half` keep their previous values, whatever `in_value` carries.
- R3: For a finite input whose rounded magnitude is at most 65504, `hi_half` is the input rounded to half precision (sign bit 15, 5-bit exponent field with bias 15 in bits 14:10, 10-bit fraction in bits 9:0). Rounding is to nearest with ties to even, with subnormal halves (exponent field 0) below 2^-14, and the input's sign is kept even when the result is zero.
- R4: For such an input, `lo_half` is the exact residual (input − high half) multiplied by 2^11 and rounded to half precision by the same rule. When the residual is exactly zero, `lo_half` is 0x0000.
- R5: `lo_scale` always reads 11.
- R6: In two cases `hi_half` is signed infinity (0x7C00 or 0xFC00) and `lo_half` is 0x0000: the input is an infinity, or the input's magnitude rounds above 65504.
- R7: For a not-a-number input (exponent field all ones, fraction nonzero), `hi_half` is 0x7E00 and `lo_half` is 0x0000.
- R8: Single-precision subnormal inputs are converted by their value and are not flushed. The high half is a signed zero and the low half is the rounded value of input × 2^11.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | `in_value` holds a value to split |
| in_value | input | 32 | Single-precision input |
| out_valid | output | 1 | Outputs hold a newly split value |
| hi_half | output | 16 | High half-precision part |
| lo_half | output | 16 | Scaled low half-precision part |
| lo_scale | output | 5 | Power of two that was applied to the low part |

## Verification
The bench goes after three kinds of corner case: rounding ties, boundary crossings and scaling. For ties, fraction patterns put the discarded bits of the high half exactly at one half with both even and odd kept bits. A design that rounds half-up, or that truncates, gives a high half one unit off and a low half of the wrong sign. For boundaries, the sweep runs through every input exponent, so it crosses the half-precision subnormal threshold, the carry into the next binade, and the 65504 limit. A design that loses the rounding carry, or saturates one step early or late, gives a wrong exponent field or infinity where a finite value belongs. For scaling, the bench checks the low half for tiny inputs and for inputs whose high part rounds to zero. A design that forgets the 2^11 scale, or forms the residual from a truncated significand, gives a zero or inexact low half there.

// File: rtl/fsplit_pkg.sv
// Shared constants and helpers for the single-to-half pair splitter.
// Assumes IEEE-style binary32 input and binary16 outputs.
package fsplit_pkg;
    localparam int F32_W       = 32;
    localparam int F32_EXP_W   = 8;
    localparam int F32_FRAC_W  = 23;
    localparam int F32_BIAS    = 127;
    localparam int SIG_W       = F32_FRAC_W + 1;
    localparam int H_W         = 16;
    localparam int H_EXP_W     = 5;
    localparam int H_FRAC_W    = 10;
    localparam int H_BIAS      = 15;
    localparam int H_MIN_Q     = 1 - H_BIAS - H_FRAC_W;
    localparam int EXP_CALC_W  = 10;
    localparam int SHIFT_W     = 5;

    typedef logic signed [EXP_CALC_W-1:0] exp_t;

    // Position of the most significant set bit (0 when the input is zero).
    function automatic logic [SHIFT_W-1:0] msb_pos(input logic [SIG_W-1:0] v);
        logic [SHIFT_W-1:0] p;
        p = '0;
        for (int i = 0; i < SIG_W; i++) begin
            if (v[i]) p = SHIFT_W'(i);
        end
        return p;
    endfunction
endpackage

// File: rtl/fsplit_unpack.sv
// Decodes a binary32 word into sign, class flags, an integer significand
// and the power of two that scales it (value = mag * 2^pexp).
// Assumes subnormals use the minimum exponent with no hidden bit.
module fsplit_unpack
    import fsplit_pkg::*;
(
    input  logic [F32_W-1:0] raw,
    output logic             sign,
    output logic             is_nan,
    output logic             is_inf,
    output logic [SIG_W-1:0] mag,
    output exp_t             pexp
);
    logic [F32_EXP_W-1:0]  efield;
    logic [F32_FRAC_W-1:0] ffield;
    logic [F32_EXP_W-1:0]  eff;

    // Field split, class detection and significand/exponent formation.
    always_comb begin
        sign   = raw[F32_W-1];
        efield = raw[F32_W-2 -: F32_EXP_W];
        ffield = raw[F32_FRAC_W-1:0];
        is_nan = (&efield) && (ffield != '0);
        is_inf = (&efield) && (ffield == '0);
        eff    = (efield == '0) ? F32_EXP_W'(1) : efield;
        mag    = {efield != '0, ffield};
        pexp   = $signed({{(EXP_CALC_W-F32_EXP_W){1'b0}}, eff})
                 - exp_t'(F32_BIAS + F32_FRAC_W);
    end
endmodule

// File: rtl/fsplit_round.sv
// Rounds a value given as mag * 2^pexp to binary16, round to nearest even.
// Produces subnormals below the normal range and signed infinity on
// overflow. Assumes mag fits in SIG_W bits; zero gives a signed zero.
module fsplit_round
    import fsplit_pkg::*;
(
    input  logic             sign,
    input  logic [SIG_W-1:0] mag,
    input  exp_t             pexp,
    output logic [H_W-1:0]   half
);
    localparam exp_t FRAC_E  = exp_t'(H_FRAC_W);
    localparam exp_t MIN_Q   = exp_t'(H_MIN_Q);
    localparam exp_t MAX_SH  = exp_t'(SIG_W + 2);
    localparam exp_t EXP_OFS = exp_t'(H_BIAS + H_FRAC_W);
    localparam exp_t EXP_INF = exp_t'((1 << H_EXP_W) - 1);
    localparam int   RS_W    = H_FRAC_W + 2;

    logic [SHIFT_W-1:0] lead;
    logic [SHIFT_W-1:0] shc;
    exp_t               top_e, q, sh, qn, field;
    logic [31:0]        mz, trunc, rem, halfv;
    logic               up;
    logic [RS_W-1:0]    rsum;
    logic [RS_W-2:0]    rn;

    // Choose the output quantum and round the significand onto it.
    always_comb begin
        lead  = msb_pos(mag);
        top_e = pexp + $signed({{(EXP_CALC_W-SHIFT_W){1'b0}}, lead});
        q     = ((top_e - FRAC_E) < MIN_Q) ? MIN_Q : (top_e - FRAC_E);
        sh    = q - pexp;
        mz    = 32'(mag);
        shc   = '0;
        trunc = '0;
        rem   = '0;
        halfv = '0;
        up    = 1'b0;
        if (sh > 0) begin
            shc   = (sh > MAX_SH) ? MAX_SH[SHIFT_W-1:0] : sh[SHIFT_W-1:0];
            trunc = mz >> shc;
            rem   = mz & ((32'd1 << shc) - 32'd1);
            halfv = 32'd1 << (shc - 1'b1);
            up    = (rem > halfv) || ((rem == halfv) && trunc[0]);
            rsum  = RS_W'(trunc + 32'(up));
        end else begin
            rsum  = RS_W'(mz << (pexp - q));
        end
    end

    // Fold a rounding carry into the exponent and pack the half word.
    always_comb begin
        rn = rsum[RS_W-1] ? ((RS_W-1)'(1) << H_FRAC_W) : rsum[RS_W-2:0];
        qn = rsum[RS_W-1] ? (q + exp_t'(1)) : q;
        field = qn + EXP_OFS;
        if (mag == '0)
            half = {sign, {(H_W-1){1'b0}}};
        else if (!rn[H_FRAC_W])
            half = {sign, {H_EXP_W{1'b0}}, rn[H_FRAC_W-1:0]};
        else if (field >= EXP_INF)
            half = {sign, {H_EXP_W{1'b1}}, {H_FRAC_W{1'b0}}};
        else
            half = {sign, field[H_EXP_W-1:0], rn[H_FRAC_W-1:0]};
    end
endmodule

// File: rtl/fsplit_resid.sv
// Forms the exact difference between the input significand and the
// rounded high half, both brought to the input's power of two.
// Assumes the high half is finite; its sign equals the input's sign.
module fsplit_resid
    import fsplit_pkg::*;
(
    input  logic [SIG_W-1:0] mag,
    input  exp_t             pexp,
    input  logic [H_W-2:0]   hi_mag,
    output logic             res_neg,
    output logic [SIG_W-1:0] res_mag
);
    localparam int   ACC_W   = 2 * SIG_W;
    localparam exp_t EXP_OFS = exp_t'(H_BIAS + H_FRAC_W);
    localparam exp_t MAX_SH  = exp_t'(SIG_W + 2);

    logic [H_EXP_W-1:0]          hfield;
    logic [H_FRAC_W:0]           hsig;
    exp_t                        hq, sh;
    logic [SHIFT_W-1:0]          shc;
    logic [ACC_W-1:0]            aligned;
    logic signed [ACC_W-1:0]     diff, absd;

    // Decode the high half, align it to the input and subtract.
    always_comb begin
        hfield  = hi_mag[H_W-2 -: H_EXP_W];
        hsig    = {hfield != '0, hi_mag[H_FRAC_W-1:0]};
        hq      = $signed({{(EXP_CALC_W-H_EXP_W){1'b0}},
                           (hfield == '0) ? H_EXP_W'(1) : hfield}) - EXP_OFS;
        sh      = hq - pexp;
        if (sh <= 0)          shc = '0;
        else if (sh > MAX_SH) shc = MAX_SH[SHIFT_W-1:0];
        else                  shc = sh[SHIFT_W-1:0];
        aligned = ACC_W'(hsig) << shc;
        diff    = $signed(ACC_W'(mag)) - $signed(aligned);
        res_neg = diff < 0;
        absd    = res_neg ? -diff : diff;
        res_mag = SIG_W'(absd);
    end
endmodule

// File: rtl/fp32_half_splitter.sv
// Splits a binary32 value into a rounded binary16 high half and a binary16
// low half holding the exact residual times 2^SCALE_LOG2. One register
// stage; data outputs hold while in_valid is low. Synchronous active-low reset.
module fp32_half_splitter
    import fsplit_pkg::*;
#(
    parameter int SCALE_LOG2 = H_FRAC_W + 1,
    parameter int SCALE_W    = 5
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               in_valid,
    input  logic [F32_W-1:0]   in_value,
    output logic               out_valid,
    output logic [H_W-1:0]     hi_half,
    output logic [H_W-1:0]     lo_half,
    output logic [SCALE_W-1:0] lo_scale
);
    localparam logic [H_W-1:0] QNAN_H = {1'b0, {H_EXP_W{1'b1}}, 1'b1, {(H_FRAC_W-1){1'b0}}};

    logic             x_sign, x_nan, x_inf;
    logic [SIG_W-1:0] x_mag, res_mag;
    exp_t             x_pexp, lo_pexp;
    logic             res_neg;
    logic [H_W-1:0]   hi_raw, lo_raw, hi_next, lo_next;

    fsplit_unpack u_unpack (
        .raw(in_value), .sign(x_sign), .is_nan(x_nan), .is_inf(x_inf),
        .mag(x_mag), .pexp(x_pexp)
    );

    fsplit_round u_hi_round (
        .sign(x_sign), .mag(x_mag), .pexp(x_pexp), .half(hi_raw)
    );

    fsplit_resid u_resid (
        .mag(x_mag), .pexp(x_pexp), .hi_mag(hi_raw[H_W-2:0]),
        .res_neg(res_neg), .res_mag(res_mag)
    );

    assign lo_pexp = x_pexp + exp_t'(SCALE_LOG2);

    fsplit_round u_lo_round (
        .sign(x_sign ^ res_neg), .mag(res_mag), .pexp(lo_pexp), .half(lo_raw)
    );

    assign lo_scale = SCALE_W'(SCALE_LOG2);

    // Apply special-value and saturation rules to the rounded halves.
    always_comb begin
        if (x_nan) begin
            hi_next = QNAN_H;
            lo_next = '0;
        end else if (x_inf) begin
            hi_next = {x_sign, {H_EXP_W{1'b1}}, {H_FRAC_W{1'b0}}};
            lo_next = '0;
        end else if (&hi_raw[H_W-2 -: H_EXP_W]) begin
            hi_next = hi_raw;
            lo_next = '0;
        end else begin
            hi_next = hi_raw;
            lo_next = (res_mag == '0) ? '0 : lo_raw;
        end
    end

    // Output register: valid follows the input, data loads only when valid.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            hi_half   <= '0;
            lo_half   <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                hi_half <= hi_next;
                lo_half <= lo_next;
            end
        end
    end
endmodule

// File: rtl/fp32_half_splitter_chk.sv
// Temporal properties of the pair splitter, attached to every instance
// of the top module through the bind statement below.
module fp32_half_splitter_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        in_valid,
    input logic [31:0] in_value,
    input logic        out_valid,
    input logic [15:0] hi_half,
    input logic [15:0] lo_half
);
    logic in_is_nan;
    assign in_is_nan = (&in_value[30:23]) && (in_value[22:0] != 23'h0);

    // R1
    valid_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> out_valid == $past(in_valid));

    // R2
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(hi_half) && $stable(lo_half));

    // R3
    hi_sign_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && !in_is_nan |=> hi_half[15] == $past(in_value[31]));

    // R4
    lo_finite_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> lo_half[14:10] != 5'h1F);

    // R6
    inf_lo_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && hi_half[14:0] == 15'h7C00 |-> lo_half == 16'h0000);

    // R7
    nan_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && in_is_nan |=> hi_half == 16'h7E00 && lo_half == 16'h0000);
endmodule

bind fp32_half_splitter fp32_half_splitter_chk u_chk (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_value(in_value),
    .out_valid(out_valid), .hi_half(hi_half), .lo_half(lo_half)
);

// File: tb/fp32_half_splitter_test.sv
`timescale 1ns/1ps
module fp32_half_splitter_test;
    localparam int NPAT = 24;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        in_valid;
    logic [31:0] in_value;
    logic        out_valid;
    logic [15:0] hi_half, lo_half;
    logic [4:0]  lo_scale;

    int  n_checks = 0;
    int  n_errors = 0;
    bit  finished = 0;
    logic [15:0] exp_hi, exp_lo;
    string tag_hi, tag_lo;

    fp32_half_splitter uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_value(in_value),
        .out_valid(out_valid), .hi_half(hi_half), .lo_half(lo_half),
        .lo_scale(lo_scale)
    );

    always #2 clk = ~clk;

    function automatic real p2(int n);
        return 2.0 ** n;
    endfunction

    // Arithmetic round-to-nearest-even of a real magnitude into binary16.
    function automatic logic [15:0] to_half(logic s, real a);
        int k, q, fld;
        real t, fl, fr;
        int r;
        if (a == 0.0) return {s, 15'h0};
        k = 0;
        while (a >= p2(k + 1)) k++;
        while (a < p2(k)) k--;
        q = (k - 10 < -24) ? -24 : k - 10;
        t = a / p2(q);
        fl = $floor(t);
        fr = t - fl;
        r = $rtoi(fl);
        if (fr > 0.5 || (fr == 0.5 && r[0])) r = r + 1;
        if (r == 2048) begin r = 1024; q = q + 1; end
        if (r < 1024) return {s, 5'd0, r[9:0]};
        fld = q + 25;
        if (fld >= 31) return {s, 5'h1F, 10'h0};
        return {s, fld[4:0], r[9:0]};
    endfunction

    function automatic real half_mag(logic [15:0] h);
        int f;
        f = int'(h[14:10]);
        if (f == 0) return real'(int'(h[9:0])) * p2(-24);
        return real'(1024 + int'(h[9:0])) * p2(f - 25);
    endfunction

    // Expected outputs from the requirements, computed with reals.
    task automatic model(logic [31:0] v);
        logic s;
        int e, m;
        real a, d;
        s = v[31];
        e = int'(v[30:23]);
        m = int'(v[22:0]);
        tag_hi = "R3"; tag_lo = "R4";
        if (e == 255 && m != 0) begin
            exp_hi = 16'h7E00; exp_lo = 16'h0; tag_hi = "R7"; tag_lo = "R7";
        end else if (e == 255) begin
            exp_hi = {s, 15'h7C00}; exp_lo = 16'h0; tag_hi = "R6"; tag_lo = "R6";
        end else begin
            if (e == 0) begin a = real'(m) * p2(-149); tag_lo = "R8"; end
            else a = real'(m + 8388608) * p2(e - 150);
            exp_hi = to_half(s, a);
            if (exp_hi[14:0] == 15'h7C00) begin
                exp_lo = 16'h0; tag_hi = "R6"; tag_lo = "R6";
            end else begin
                d = a - half_mag(exp_hi);
                if (d == 0.0) exp_lo = 16'h0;
                else if (d < 0.0) exp_lo = to_half(~s, -d * p2(11));
                else exp_lo = to_half(s, d * p2(11));
            end
        end
    endtask

    task automatic chk(string tag, string what, logic [15:0] act, logic [15:0] expv);
        n_checks++;
        if (act !== expv) begin
            n_errors++;
            $display("FAIL %s %s: actual %h expected %h (input %h)", tag, what, act, expv, in_value);
        end
    endtask

    // Drive one valid vector at a falling edge, check one clock later.
    task automatic run_vec(logic [31:0] v);
        in_valid = 1'b1;
        in_value = v;
        model(v);
        @(negedge clk);
        chk("R1", "out_valid", {15'h0, out_valid}, 16'h1);
        chk(tag_hi, "hi_half", hi_half, exp_hi);
        chk(tag_lo, "lo_half", lo_half, exp_lo);
    endtask

    task automatic directed(logic [31:0] v, logic [15:0] eh, logic [15:0] el, string tag);
        in_valid = 1'b1;
        in_value = v;
        @(negedge clk);
        chk(tag, "hi_half directed", hi_half, eh);
        chk(tag, "lo_half directed", lo_half, el);
    endtask

    function automatic logic [22:0] pat(int i);
        logic [31:0] x;
        case (i)
            0: return 23'h000000;
            1: return 23'h000001;
            2: return 23'h7FFFFF;
            3: return 23'h400000;
            4: return 23'h001000;
            5: return 23'h003000;
            6: return 23'h000FFF;
            7: return 23'h001001;
            8: return 23'h7FF000;
            9: return 23'h7FE000;
            10: return 23'h2AAAAA;
            11: return 23'h555555;
            default: begin
                x = 32'(i) * 32'h9E3779B9;
                x = x ^ (x >> 13);
                x = x * 32'h85EBCA6B;
                return x[22:0];
            end
        endcase
    endfunction

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [15:0] held_hi, held_lo;
        rst_n = 1'b0;
        in_valid = 1'b0;
        in_value = 32'h0;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1", "reset out_valid", {15'h0, out_valid}, 16'h0);
        chk("R1", "reset hi_half", hi_half, 16'h0);
        chk("R1", "reset lo_half", lo_half, 16'h0);
        // R5: fixed scale
        chk("R5", "lo_scale", {11'h0, lo_scale}, 16'd11);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", "idle out_valid", {15'h0, out_valid}, 16'h0);

        // Directed values with hand-computed results.
        directed(32'h3F800000, 16'h3C00, 16'h0000, "R3");   // 1.0
        directed(32'h3F800001, 16'h3C00, 16'h0C00, "R4");   // 1+2^-23: residual 2^-12 after scale
        directed(32'hBF800001, 16'hBC00, 16'h8C00, "R4");
        directed(32'h477FE000, 16'h7BFF, 16'h0000, "R3");   // 65504
        directed(32'h477FF000, 16'h7C00, 16'h0000, "R6");   // tie above 65504 rounds out
        directed(32'h7F800000, 16'h7C00, 16'h0000, "R6");
        directed(32'hFF800000, 16'hFC00, 16'h0000, "R6");
        directed(32'h7FC00000, 16'h7E00, 16'h0000, "R7");
        directed(32'hFFFFFFFF, 16'h7E00, 16'h0000, "R7");
        directed(32'h80000000, 16'h8000, 16'h0000, "R3");   // negative zero
        directed(32'h33000000, 16'h0000, 16'h0400, "R8");   // 2^-25 tie to zero, residual 2^-14

        // Sweep every exponent, a set of fraction patterns and both signs.
        for (int e = 0; e < 256; e++) begin
            for (int p = 0; p < NPAT; p++) begin
                for (int s = 0; s < 2; s++) begin
                    run_vec({s[0], e[7:0], pat(p)});
                end
            end
        end

        // R2: idle cycles leave the data outputs untouched.
        held_hi = exp_hi;
        held_lo = exp_lo;
        in_valid = 1'b0;
        for (int i = 0; i < 4; i++) begin
            in_value = 32'h3F800000 + 32'(i * 4099);
            @(negedge clk);
            chk("R1", "idle out_valid", {15'h0, out_valid}, 16'h0);
            chk("R2", "held hi_half", hi_half, held_hi);
            chk("R2", "held lo_half", lo_half, held_lo);
        end
        run_vec(32'h40490FDB);
        chk("R5", "lo_scale end", {11'h0, lo_scale}, 16'd11);
        in_valid = 1'b0;
        @(negedge clk);
        finish_run();
    end
endmodule